// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block watches bus write cycles aimed at the command space of a flash memory. The memory has one program bank and two data banks. Each accepted write is one whole command. A write of the exit code returns the interpreter to plain read operation. A write of an entry code hands the page assembly buffer to one bank. Every other write counts as a sequence fault. An external program/erase controller reports the busy state of each bank. The interpreter mirrors those busy flags in its status outputs and uses them to refuse page entry to a bank that is busy.

The write address is split into a 2-bit window field in the top bits and a 16-bit offset below it. Window 0 is the program bank, window 1 is data bank 0, window 2 is data bank 1, and window 3 is unmapped. The page-owner state machine has four states:

- `ST_READ`: no page mode.
- `ST_PAGE_P`: the program bank owns the buffer.
- `ST_PAGE_D0`: data bank 0 owns the buffer.
- `ST_PAGE_D1`: data bank 1 owns the buffer.

It has four named transitions:

- *exit*: any state to `ST_READ` on the exit command.
- *claim*: any state to the addressed bank's page state when entry is accepted. This also restarts the bank that already owns the buffer.
- *refuse*: no state change when the target bank is busy.
- *fault*: any state to `ST_READ` on an unrecognised write.

When entry is accepted, the block pulses a buffer-pointer clear. It also publishes the last word index of the active buffer. The buffer is 256 bytes for the program bank and 128 bytes for a data bank, with 8-byte words.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset all status outputs, `page_owner`, `buf_ptr_clr` and `buf_last_word` are zero.
- R2: A write of data F0h to offset 5554h in window 0, 1 or 2 is the exit command. It forces `ST_READ` from the next cycle, so `page_owner` is 0 and both page bits are low.
- R3: The exit command clears `stat_seq_err` from the next cycle and never sets it. This holds even when the exit command arrives in the middle of page mode.
- R4: `stat_busy[i]` equals `bank_busy[i]` from the previous cycle, whatever command is written. Bit 0 is the program bank, bit 1 is data bank 0 and bit 2 is data bank 1.
- R5: A write of 50h to offset 5554h in window 0, with `bank_busy[0]` low in that cycle, enters `ST_PAGE_P`. From the next cycle `page_owner` is 001b, `stat_pgm_page` is 1 and `buf_last_word` is 31. `buf_ptr_clr` is high for exactly that one cycle.
- R6: A write of 5Dh to offset 5554h in window 1 or 2, with that bank idle, enters `ST_PAGE_D0` or `ST_PAGE_D1`. `page_owner` becomes 010b or 100b, `stat_dat_page` is 1 and `buf_last_word` is 15.
- R7: An accepted entry while page mode is active replaces the owner, even when the new owner is the same bank. `buf_ptr_clr` pulses again, and `page_owner` never has more than one bit set.
- R8: An entry command whose target bank has its busy input high in the write cycle is ignored. `page_owner` is unchanged and `stat_seq_err` is set.
- R9: Entry to an idle bank is accepted while other banks are busy.
- R10: Every other write sets `stat_seq_err` and forces `ST_READ`. This covers a wrong offset, a wrong data code, any write to window 3, 50h in a data window and 5Dh in the program window.
- R11: `stat_seq_err` stays set until an exit command or a reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one command cycle |
| wr_addr | input | 18 | Window field in [17:16], offset in [15:0] |
| wr_data | input | 8 | Command code |
| bank_busy | input | 3 | Busy input from the program/erase controller, one bit per bank |
| stat_busy | output | 3 | Registered busy flags |
| stat_pgm_page | output | 1 | Program bank owns the page buffer |
| stat_dat_page | output | 1 | A data bank owns the page buffer |
| stat_seq_err | output | 1 | Sticky sequence fault flag |
| page_owner | output | 3 | One-hot owner of the page buffer |
| buf_ptr_clr | output | 1 | One-cycle pulse that resets the buffer pointer to word 0 |
| buf_last_word | output | 5 | Last word index of the owner's buffer, 0 when no owner |

## Verification
Two events can meet in one cycle. In the first, a bank's busy input rises in the same cycle that an entry command names that bank. The bench drives both on one falling edge. It expects the entry to be refused and the fault flag to be set, while the busy flag appears one cycle later. In the second, an exit command arrives together with a change of the busy inputs. In that case the page owner and fault flag must clear while the busy flags still follow the new inputs. A scoreboard model predicts every cycle's full output word from the requirements alone.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_EXIT,
        CMD_ENTRY,
        CMD_BAD
    } cmd_e;

    typedef enum logic [1:0] {
        ST_READ,
        ST_PAGE_P,
        ST_PAGE_D0,
        ST_PAGE_D1
    } page_st_e;

    localparam logic [7:0] CODE_EXIT    = 8'hF0;
    localparam logic [7:0] CODE_ENTRY_P = 8'h50;
    localparam logic [7:0] CODE_ENTRY_D = 8'h5D;

    localparam logic [1:0] WIN_PROG   = 2'd0;
    localparam logic [1:0] WIN_UNUSED = 2'd3;

endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
    import flash_cmd_pkg::*;
#(
    parameter int unsigned OFFSET_W   = 16,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned CMD_OFFSET = 'h5554
) (
    input  logic                  wr_en,
    input  logic [OFFSET_W+1:0]   wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output cmd_e                  cmd,
    output logic [1:0]            bank
);

    logic [1:0]          window;
    logic [OFFSET_W-1:0] offset;
    logic                off_hit;

    assign window  = wr_addr[OFFSET_W +: 2];
    assign offset  = wr_addr[OFFSET_W-1:0];
    assign off_hit = (offset == OFFSET_W'(CMD_OFFSET));
    assign bank    = window;

    always_comb begin
        cmd = CMD_NONE;
        if (wr_en) begin
            if (!off_hit || window == WIN_UNUSED) begin
                cmd = CMD_BAD;
            end else if (wr_data == DATA_W'(CODE_EXIT)) begin
                cmd = CMD_EXIT;
            end else if (wr_data == DATA_W'(CODE_ENTRY_P)) begin
                cmd = (window == WIN_PROG) ? CMD_ENTRY : CMD_BAD;
            end else if (wr_data == DATA_W'(CODE_ENTRY_D)) begin
                cmd = (window != WIN_PROG) ? CMD_ENTRY : CMD_BAD;
            end else begin
                cmd = CMD_BAD;
            end
        end
    end

endmodule

// File: rtl/fcs_page_fsm.sv
module fcs_page_fsm
    import flash_cmd_pkg::*;
#(
    parameter int unsigned PTR_W   = 5,
    parameter int unsigned PF_LAST = 31,
    parameter int unsigned DF_LAST = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd,
    input  logic [1:0]       bank,
    input  logic [2:0]       busy_in,
    output logic [2:0]       owner,
    output logic             pgm_page,
    output logic             dat_page,
    output logic             ptr_clr,
    output logic [PTR_W-1:0] buf_last,
    output logic             err_set,
    output logic             err_clr
);

    page_st_e state_q, state_d;
    logic     tgt_busy;
    logic     claim, refuse, fault;
    logic     ptr_clr_q;

    always_comb begin
        tgt_busy = (bank == WIN_UNUSED) ? 1'b0 : busy_in[bank];
    end

    function automatic page_st_e bank_state(input logic [1:0] b);
        unique case (b)
            2'd0:    return ST_PAGE_P;
            2'd1:    return ST_PAGE_D0;
            default: return ST_PAGE_D1;
        endcase
    endfunction

    // transition selection
    always_comb begin
        state_d = state_q;
        claim   = 1'b0;
        refuse  = 1'b0;
        fault   = 1'b0;
        unique case (cmd)
            CMD_NONE:  ;
            CMD_EXIT:  state_d = ST_READ;
            CMD_ENTRY: begin
                if (tgt_busy) begin
                    refuse = 1'b1;
                end else begin
                    claim   = 1'b1;
                    state_d = bank_state(bank);
                end
            end
            CMD_BAD: begin
                fault   = 1'b1;
                state_d = ST_READ;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_READ;
            ptr_clr_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            ptr_clr_q <= claim;
        end
    end

    // outputs
    always_comb begin
        owner    = 3'b000;
        pgm_page = 1'b0;
        dat_page = 1'b0;
        buf_last = '0;
        unique case (state_q)
            ST_READ:    ;
            ST_PAGE_P: begin
                owner    = 3'b001;
                pgm_page = 1'b1;
                buf_last = PTR_W'(PF_LAST);
            end
            ST_PAGE_D0: begin
                owner    = 3'b010;
                dat_page = 1'b1;
                buf_last = PTR_W'(DF_LAST);
            end
            ST_PAGE_D1: begin
                owner    = 3'b100;
                dat_page = 1'b1;
                buf_last = PTR_W'(DF_LAST);
            end
        endcase
    end

    assign ptr_clr = ptr_clr_q;
    assign err_set = refuse | fault;
    assign err_clr = (cmd == CMD_EXIT);

    AST_EXIT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_EXIT) |=> (owner == 3'b000)); // R2

    AST_BUSY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ENTRY && tgt_busy) |=> (owner == $past(owner) && !ptr_clr)); // R8

    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(owner)); // R7

    AST_CLR_WITH_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |-> (owner != 3'b000)); // R5

    AST_FAULT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_BAD) |=> (!pgm_page && !dat_page)); // R10

endmodule

// File: rtl/fcs_status.sv
module fcs_status #(
    parameter int unsigned NUM_BANKS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] busy_in,
    input  logic                 err_set,
    input  logic                 err_clr,
    output logic [NUM_BANKS-1:0] busy_q,
    output logic                 seq_err
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= '0;
            seq_err <= 1'b0;
        end else begin
            busy_q <= busy_in;
            if (err_clr) begin
                seq_err <= 1'b0;
            end else if (err_set) begin
                seq_err <= 1'b1;
            end
        end
    end

    AST_EXIT_NO_SQER: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> !seq_err); // R3

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && !err_clr) |=> seq_err); // R11

    AST_EXIT_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> (busy_q == $past(busy_in))); // R4

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int unsigned OFFSET_W   = 16,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned CMD_OFFSET = 'h5554,
    parameter int unsigned PF_BYTES   = 256,
    parameter int unsigned DF_BYTES   = 128,
    parameter int unsigned WORD_BYTES = 8,
    localparam int unsigned PF_WORDS  = PF_BYTES / WORD_BYTES,
    localparam int unsigned DF_WORDS  = DF_BYTES / WORD_BYTES,
    localparam int unsigned PTR_W     = $clog2(PF_WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [OFFSET_W+1:0] wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [2:0]          bank_busy,
    output logic [2:0]          stat_busy,
    output logic                stat_pgm_page,
    output logic                stat_dat_page,
    output logic                stat_seq_err,
    output logic [2:0]          page_owner,
    output logic                buf_ptr_clr,
    output logic [PTR_W-1:0]    buf_last_word
);

    cmd_e       cmd;
    logic [1:0] bank;
    logic       err_set, err_clr;

    fcs_decode #(
        .OFFSET_W   (OFFSET_W),
        .DATA_W     (DATA_W),
        .CMD_OFFSET (CMD_OFFSET)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmd     (cmd),
        .bank    (bank)
    );

    fcs_page_fsm #(
        .PTR_W   (PTR_W),
        .PF_LAST (PF_WORDS - 1),
        .DF_LAST (DF_WORDS - 1)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .bank     (bank),
        .busy_in  (bank_busy),
        .owner    (page_owner),
        .pgm_page (stat_pgm_page),
        .dat_page (stat_dat_page),
        .ptr_clr  (buf_ptr_clr),
        .buf_last (buf_last_word),
        .err_set  (err_set),
        .err_clr  (err_clr)
    );

    fcs_status #(
        .NUM_BANKS (3)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_in (bank_busy),
        .err_set (err_set),
        .err_clr (err_clr),
        .busy_q  (stat_busy),
        .seq_err (stat_seq_err)
    );

    AST_PAGE_BITS_MATCH_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_pgm_page == page_owner[0]) && (stat_dat_page == |page_owner[2:1])); // R6

endmodule

// File: tb/flash_cmd_seq_bench.sv
`timescale 1ns/1ps
module flash_cmd_seq_bench;

    typedef struct {
        logic [14:0] word;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  bank_busy = '0;
    logic [2:0]  stat_busy;
    logic        stat_pgm_page, stat_dat_page, stat_seq_err;
    logic [2:0]  page_owner;
    logic        buf_ptr_clr;
    logic [4:0]  buf_last_word;

    int   total = 0;
    int   bad = 0;
    exp_t sb[$];
    logic [2:0] m_owner = 3'b000;
    logic       m_err = 1'b0;

    always #2.5 clk = ~clk;

    flash_cmd_seq u_flash_cmd_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .bank_busy     (bank_busy),
        .stat_busy     (stat_busy),
        .stat_pgm_page (stat_pgm_page),
        .stat_dat_page (stat_dat_page),
        .stat_seq_err  (stat_seq_err),
        .page_owner    (page_owner),
        .buf_ptr_clr   (buf_ptr_clr),
        .buf_last_word (buf_last_word)
    );

    // driver: one bus cycle, expected outputs after the edge go to the scoreboard
    task automatic step(input logic w, input logic [1:0] win, input logic [15:0] off,
                        input logic [7:0] d, input logic [2:0] b, input string tag);
        exp_t e;
        logic clr;
        logic [4:0] last;
        @(negedge clk);
        wr_en = w; wr_addr = {win, off}; wr_data = d; bank_busy = b;
        clr = 1'b0;
        if (w) begin
            if (off == 16'h5554 && win != 2'd3 && d == 8'hF0) begin
                m_owner = 3'b000; m_err = 1'b0;
            end else if (off == 16'h5554 && win == 2'd0 && d == 8'h50) begin
                if (b[0]) m_err = 1'b1;
                else begin m_owner = 3'b001; clr = 1'b1; end
            end else if (off == 16'h5554 && (win == 2'd1 || win == 2'd2) && d == 8'h5D) begin
                if (b[win]) m_err = 1'b1;
                else begin m_owner = 3'b001 << win; clr = 1'b1; end
            end else begin
                m_err = 1'b1; m_owner = 3'b000;
            end
        end
        last = m_owner[0] ? 5'd31 : ((m_owner[2:1] != 2'b00) ? 5'd15 : 5'd0);
        e.word = {b, m_owner[0], |m_owner[2:1], m_err, m_owner, clr, last};
        e.tag  = tag;
        @(posedge clk);
        #1;
        sb.push_back(e);
    endtask

    // monitor
    always @(negedge clk) begin
        if (sb.size() != 0) begin
            exp_t e;
            logic [14:0] act;
            e = sb.pop_front();
            act = {stat_busy, stat_pgm_page, stat_dat_page, stat_seq_err,
                   page_owner, buf_ptr_clr, buf_last_word};
            total++;
            if (act !== e.word) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", e.tag, act, e.word);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if ({stat_busy, stat_seq_err, page_owner, buf_ptr_clr, buf_last_word} !== '0) begin
            bad++;
            $display("FAIL R1 in reset actual=%b expected=0",
                     {stat_busy, stat_seq_err, page_owner, buf_ptr_clr, buf_last_word});
        end
        rst_n = 1'b1;
        step(0, 2'd0, 16'h0000, 8'h00, 3'b000, "R1 idle after reset");
        step(1, 2'd0, 16'h5554, 8'h50, 3'b000, "R5 program entry");
        step(0, 2'd0, 16'h0000, 8'h00, 3'b000, "R5 clr one cycle");
        step(1, 2'd1, 16'h5554, 8'h5D, 3'b000, "R7 switch to data0 R6");
        step(1, 2'd2, 16'h5554, 8'h5D, 3'b001, "R9 data1 entry with program busy");
        step(1, 2'd2, 16'h5554, 8'h5D, 3'b001, "R7 re-entry same bank");
        step(1, 2'd2, 16'h5554, 8'hF0, 3'b101, "R2 exit in data1 window R4");
        step(1, 2'd1, 16'h5554, 8'h5D, 3'b100, "R6 data0 entry");
        step(1, 2'd0, 16'h5554, 8'h50, 3'b001, "R8 program busy refused");
        step(0, 2'd0, 16'h0000, 8'h00, 3'b000, "R11 error sticky");
        step(0, 2'd0, 16'h0000, 8'h00, 3'b010, "R11 error sticky busy R4");
        step(1, 2'd0, 16'h5554, 8'hF0, 3'b010, "R3 exit clears error");
        step(1, 2'd2, 16'h5554, 8'h5D, 3'b000, "R6 data1 entry");
        step(1, 2'd0, 16'h5554, 8'hA5, 3'b000, "R10 bad code aborts page");
        step(1, 2'd1, 16'h5554, 8'hF0, 3'b000, "R3 exit");
        step(1, 2'd0, 16'h5554, 8'h50, 3'b000, "R5 program entry again");
        step(1, 2'd1, 16'h5554, 8'h50, 3'b000, "R10 program code in data window");
        step(1, 2'd0, 16'h5554, 8'hF0, 3'b000, "R3 exit");
        step(1, 2'd0, 16'h5554, 8'h5D, 3'b000, "R10 data code in program window");
        step(1, 2'd0, 16'h5554, 8'hF0, 3'b000, "R3 exit");
        step(1, 2'd3, 16'h5554, 8'hF0, 3'b000, "R10 unmapped window");
        step(1, 2'd2, 16'h5554, 8'hF0, 3'b000, "R3 exit");
        step(1, 2'd0, 16'h5555, 8'hF0, 3'b000, "R10 wrong offset");
        step(1, 2'd0, 16'h5554, 8'hF0, 3'b000, "R3 exit no error");
        step(1, 2'd0, 16'h5554, 8'h50, 3'b000, "R5 program entry");
        step(1, 2'd1, 16'h5554, 8'h5D, 3'b010, "R8 busy rises with entry");
        step(0, 2'd0, 16'h0000, 8'h00, 3'b010, "R4 busy held");
        step(1, 2'd0, 16'h5554, 8'hF0, 3'b111, "R3 exit with busy change R4");
        step(1, 2'd0, 16'h5554, 8'hF0, 3'b011, "R2 repeated exit");
        step(0, 2'd0, 16'h0000, 8'h00, 3'b000, "R4 busy released");
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule